// File: doc/BRIEF.md
# Synthesizer divider programming port

This block holds the divider and fractional settings that a fractional-N synthesizer core consumes: a reference divide value, a main divide value, a swallow count and an 18-bit fractional word, plus an 8-bit enhancement field. The settings arrive in one of two ways. In serial mode a three-wire port (serial clock, serial data, load strobe) fills a 20-bit shift register. A rising edge on the load strobe or on a separate hop strobe copies that register into a holding latch, so the core sees one clean update and never a half-shifted word. A second load-enable level steers the same serial stream into the enhancement register. In direct mode the four divider fields come straight from parallel pins.

All serial-side inputs are asynchronous to the core clock. They pass through a two-stage synchronizer and are edge-detected in the core clock domain. The serial clock must therefore stay at each level for at least three core clock periods. The port has no flow control: the host paces the serial clock itself, and the control pins are plain levels.

A serial word carries a destination flag in bit 0. With the flag clear, the word updates the main divide, swallow and reference fields. With the flag set, its upper 18 bits become the fractional word. Each kind of word is latched independently.

Top module: `synth_prog_port`

## Requirements
- R1: On each synchronized rising edge of `sclk`, while `s_wr` and `e_wr` are both low, `sdata` shifts into bit 0 of the 20-bit primary register and older bits move toward bit 19, so the first bit sent ends in bit 19.
- R2: While `e_wr` is high, rising `sclk` edges shift `sdata` into the 8-bit enhancement register (first bit sent ends in bit 7), and the primary register keeps its contents.
- R3: A rising edge of `s_wr` or of `hop_wr` with primary bit 0 = 0 loads main divide = bits [19:11], swallow = bits [10:7], reference = bits [6:1]; the new values reach the outputs three core cycles after the strobe edge is sampled.
- R4: A rising edge of `s_wr` or `hop_wr` with primary bit 0 = 1 loads the fractional word from bits [19:2] and leaves the other three fields unchanged.
- R5: Without a strobe edge, the latched serial values do not change, whatever is shifted into the primary register.
- R6: With `direct` high, `r_out`, `m_out`, `a_out`, `k_out` equal the parallel pins sampled at the previous core clock edge. With `direct` low they show the latched serial values. Toggling `direct` never alters the stored serial contents.
- R7: `enh_out` shows the enhancement register while `enh_n` is low and is all zeros while `enh_n` is high, one core cycle after `enh_n` is sampled.
- R8: During and right after reset, every output, the latched serial fields and the enhancement register are zero.
- R9: When a strobe edge and an `sclk` edge are sampled in the same core cycle, the transfer takes the primary word as it was before that edge. The bit is not shifted, because `s_wr` is high. Coincident `s_wr` and `hop_wr` edges give a single transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial shift clock (asynchronous) |
| sdata | input | 1 | Serial data, first bit is most significant |
| s_wr | input | 1 | Load strobe; low enables shifting, rising edge transfers |
| e_wr | input | 1 | High steers serial data to the enhancement register |
| hop_wr | input | 1 | Alternative transfer strobe, rising edge |
| direct | input | 1 | High selects the parallel pins |
| enh_n | input | 1 | Low enables the enhancement bits |
| r_pin | input | 6 | Parallel reference divide |
| m_pin | input | 9 | Parallel main divide |
| a_pin | input | 4 | Parallel swallow count |
| k_pin | input | 18 | Parallel fractional word |
| r_out | output | 6 | Active reference divide |
| m_out | output | 9 | Active main divide |
| a_out | output | 4 | Active swallow count |
| k_out | output | 18 | Active fractional word |
| enh_out | output | 8 | Gated enhancement bits |

## Verification
Shifting and transferring are the two functions that can land in the same cycle. The bench provokes this by raising `sclk` and `s_wr` on the same core clock edge. It also raises `s_wr` and `hop_wr` together. A behavioural model applies the transfer from the pre-edge primary word and suppresses the shift because the strobe is high. It then delays the result by the pipeline depth and compares every output on every clock. A wrong ordering appears as a stale or shifted field on the outputs three cycles later.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int DEF_M_W   = 9;
  localparam int DEF_A_W   = 4;
  localparam int DEF_R_W   = 6;
  localparam int DEF_ENH_W = 8;
  localparam int DEF_SYNC  = 2;

  typedef enum logic {
    DEST_MAIN = 1'b0,
    DEST_FRAC = 1'b1
  } dest_e;

  localparam int IN_SCLK  = 0;
  localparam int IN_SDATA = 1;
  localparam int IN_SWR   = 2;
  localparam int IN_EWR   = 3;
  localparam int IN_HOP   = 4;
  localparam int IN_N     = 5;
endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prog_edge.sv
module prog_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/prog_shift.sv
module prog_shift #(
  parameter int WORD_W = 20,
  parameter int ENH_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_pulse,
  input  logic              bit_in,
  input  logic              s_wr_lvl,
  input  logic              e_wr_lvl,
  output logic [WORD_W-1:0] primary,
  output logic [ENH_W-1:0]  enh_q
);
  logic main_en;
  logic enh_en;

  assign main_en = shift_pulse & ~s_wr_lvl & ~e_wr_lvl;
  assign enh_en  = shift_pulse & e_wr_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       primary <= '0;
    else if (main_en) primary <= {primary[WORD_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enh_q <= '0;
    else if (enh_en) enh_q <= {enh_q[ENH_W-2:0], bit_in};
  end
endmodule

// File: rtl/prog_latch.sv
module prog_latch
  import synth_prog_pkg::*;
#(
  parameter int M_W = 9,
  parameter int A_W = 4,
  parameter int R_W = 6,
  parameter int K_W = 18,
  parameter int WORD_W = M_W + A_W + R_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [WORD_W-1:0] primary,
  output logic [M_W-1:0]    ser_m,
  output logic [A_W-1:0]    ser_a,
  output logic [R_W-1:0]    ser_r,
  output logic [K_W-1:0]    ser_k
);
  localparam int M_LO = WORD_W - M_W;
  localparam int A_LO = M_LO - A_W;

  dest_e dest;
  assign dest = dest_e'(primary[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_m <= '0;
      ser_a <= '0;
      ser_r <= '0;
    end else if (xfer && dest == DEST_MAIN) begin
      ser_m <= primary[WORD_W-1:M_LO];
      ser_a <= primary[M_LO-1:A_LO];
      ser_r <= primary[R_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ser_k <= '0;
    else if (xfer && dest == DEST_FRAC) ser_k <= primary[WORD_W-1:WORD_W-K_W];
  end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
  import synth_prog_pkg::*;
#(
  parameter int M_W    = DEF_M_W,
  parameter int A_W    = DEF_A_W,
  parameter int R_W    = DEF_R_W,
  parameter int K_W    = DEF_M_W + DEF_A_W + DEF_R_W - 1,
  parameter int ENH_W  = DEF_ENH_W,
  parameter int SYNC_N = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             s_wr,
  input  logic             e_wr,
  input  logic             hop_wr,
  input  logic             direct,
  input  logic             enh_n,
  input  logic [R_W-1:0]   r_pin,
  input  logic [M_W-1:0]   m_pin,
  input  logic [A_W-1:0]   a_pin,
  input  logic [K_W-1:0]   k_pin,
  output logic [R_W-1:0]   r_out,
  output logic [M_W-1:0]   m_out,
  output logic [A_W-1:0]   a_out,
  output logic [K_W-1:0]   k_out,
  output logic [ENH_W-1:0] enh_out
);
  localparam int WORD_W = M_W + A_W + R_W + 1;

  logic [IN_N-1:0]   raw;
  logic [IN_N-1:0]   lvl;
  logic [2:0]        rise;
  logic              xfer;
  logic [WORD_W-1:0] primary;
  logic [ENH_W-1:0]  enh_q;
  logic [M_W-1:0]    ser_m;
  logic [A_W-1:0]    ser_a;
  logic [R_W-1:0]    ser_r;
  logic [K_W-1:0]    ser_k;
  logic              e_wr_lvl;

  always_comb begin
    raw           = '0;
    raw[IN_SCLK]  = sclk;
    raw[IN_SDATA] = sdata;
    raw[IN_SWR]   = s_wr;
    raw[IN_EWR]   = e_wr;
    raw[IN_HOP]   = hop_wr;
  end

  prog_sync #(.N(IN_N), .STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
  );

  prog_edge #(.N(3)) edge_i (
    .clk(clk), .rst_n(rst_n),
    .lvl({lvl[IN_HOP], lvl[IN_SWR], lvl[IN_SCLK]}),
    .rise(rise)
  );

  assign xfer     = rise[1] | rise[2];
  assign e_wr_lvl = lvl[IN_EWR];

  prog_shift #(.WORD_W(WORD_W), .ENH_W(ENH_W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .shift_pulse(rise[0]),
    .bit_in(lvl[IN_SDATA]),
    .s_wr_lvl(lvl[IN_SWR]),
    .e_wr_lvl(e_wr_lvl),
    .primary(primary),
    .enh_q(enh_q)
  );

  prog_latch #(.M_W(M_W), .A_W(A_W), .R_W(R_W), .K_W(K_W), .WORD_W(WORD_W)) latch_i (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .primary(primary),
    .ser_m(ser_m), .ser_a(ser_a), .ser_r(ser_r), .ser_k(ser_k)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_out   <= '0;
      m_out   <= '0;
      a_out   <= '0;
      k_out   <= '0;
      enh_out <= '0;
    end else begin
      r_out   <= direct ? r_pin : ser_r;
      m_out   <= direct ? m_pin : ser_m;
      a_out   <= direct ? a_pin : ser_a;
      k_out   <= direct ? k_pin : ser_k;
      enh_out <= enh_n ? '0 : enh_q;
    end
  end
endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk #(
  parameter int M_W = 9,
  parameter int A_W = 4,
  parameter int R_W = 6,
  parameter int K_W = 18,
  parameter int ENH_W = 8,
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              direct,
  input logic              enh_n,
  input logic [M_W-1:0]    m_pin,
  input logic [K_W-1:0]    k_pin,
  input logic [M_W-1:0]    m_out,
  input logic [K_W-1:0]    k_out,
  input logic [ENH_W-1:0]  enh_out,
  input logic              xfer,
  input logic              e_wr_lvl,
  input logic [WORD_W-1:0] primary,
  input logic [M_W-1:0]    ser_m,
  input logic [A_W-1:0]    ser_a,
  input logic [R_W-1:0]    ser_r,
  input logic [K_W-1:0]    ser_k
);
  assert_enh_shift_keeps_primary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr_lvl |=> $stable(primary));

  assert_main_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !primary[0]) |=> (ser_m == $past(primary[WORD_W-1:WORD_W-M_W])));

  assert_frac_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && primary[0]) |=> (ser_k == $past(primary[WORD_W-1:WORD_W-K_W])));

  assert_hold_between_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(ser_m) && $stable(ser_a) && $stable(ser_r) && $stable(ser_k)));

  assert_direct_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    direct |=> (m_out == $past(m_pin) && k_out == $past(k_pin)));

  assert_serial_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !direct |=> (m_out == $past(ser_m) && k_out == $past(ser_k)));

  assert_enh_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enh_n |=> (enh_out == '0));
endmodule

bind synth_prog_port synth_prog_port_chk #(
  .M_W(M_W), .A_W(A_W), .R_W(R_W), .K_W(K_W), .ENH_W(ENH_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .direct(direct), .enh_n(enh_n),
  .m_pin(m_pin), .k_pin(k_pin), .m_out(m_out), .k_out(k_out), .enh_out(enh_out),
  .xfer(xfer), .e_wr_lvl(e_wr_lvl), .primary(primary),
  .ser_m(ser_m), .ser_a(ser_a), .ser_r(ser_r), .ser_k(ser_k)
);

// File: tb/synth_prog_port_tb_top.sv
module synth_prog_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, s_wr = 1'b0, e_wr = 1'b0, hop_wr = 1'b0;
  logic direct = 1'b0, enh_n = 1'b1;
  logic [5:0]  r_pin = '0;
  logic [8:0]  m_pin = '0;
  logic [3:0]  a_pin = '0;
  logic [17:0] k_pin = '0;
  logic [5:0]  r_out;
  logic [8:0]  m_out;
  logic [3:0]  a_out;
  logic [17:0] k_out;
  logic [7:0]  enh_out;

  always #10 clk = ~clk;

  synth_prog_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .s_wr(s_wr),
    .e_wr(e_wr), .hop_wr(hop_wr), .direct(direct), .enh_n(enh_n),
    .r_pin(r_pin), .m_pin(m_pin), .a_pin(a_pin), .k_pin(k_pin),
    .r_out(r_out), .m_out(m_out), .a_out(a_out), .k_out(k_out), .enh_out(enh_out)
  );

  typedef struct {
    int unsigned m, a, r, k, e;
  } snap_t;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R8";

  int unsigned mp, me, mm, ma, mr, mk;
  bit p_sclk, p_swr, p_hop;
  snap_t hq[$];
  int unsigned exp_m, exp_a, exp_r, exp_k, exp_e;

  task automatic clear_model();
    mp = 0; me = 0; mm = 0; ma = 0; mr = 0; mk = 0;
    p_sclk = 0; p_swr = 0; p_hop = 0;
    hq.delete();
    for (int i = 0; i < 4; i++) hq.push_back('{0, 0, 0, 0, 0});
    exp_m = 0; exp_a = 0; exp_r = 0; exp_k = 0; exp_e = 0;
  endtask

  initial clear_model();

  // Behavioural reference: transfer sees the pre-edge word, then shift.
  always @(posedge clk) begin
    if (!rst_n) begin
      clear_model();
    end else begin
      bit xf, sr;
      snap_t s;
      xf = (s_wr && !p_swr) || (hop_wr && !p_hop);
      sr = sclk && !p_sclk;
      if (xf) begin
        if (mp[0]) mk = (mp >> 2) & 32'h3FFFF;
        else begin
          mm = (mp >> 11) & 32'h1FF;
          ma = (mp >> 7) & 32'hF;
          mr = (mp >> 1) & 32'h3F;
        end
      end
      if (sr) begin
        if (e_wr)       me = ((me << 1) | 32'(sdata)) & 32'hFF;
        else if (!s_wr) mp = ((mp << 1) | 32'(sdata)) & 32'hFFFFF;
      end
      p_sclk = sclk; p_swr = s_wr; p_hop = hop_wr;
      s = '{mm, ma, mr, mk, me};
      hq.push_front(s);
      while (hq.size() > 4) void'(hq.pop_back());
      exp_m = direct ? 32'(m_pin) : hq[3].m;
      exp_a = direct ? 32'(a_pin) : hq[3].a;
      exp_r = direct ? 32'(r_pin) : hq[3].r;
      exp_k = direct ? 32'(k_pin) : hq[3].k;
      exp_e = enh_n ? 0 : hq[3].e;
    end
  end

  task automatic cmp(string f, int unsigned act, int unsigned exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s field %s: actual %0h expected %0h at cycle %0d", phase, f, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    vectors++;
    cmp("m", 32'(m_out), exp_m);
    cmp("a", 32'(a_out), exp_a);
    cmp("r", 32'(r_out), exp_r);
    cmp("k", 32'(k_out), exp_k);
    cmp("enh", 32'(enh_out), exp_e);
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired: actual %0d cycles expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    sdata = b; sclk = 1'b0; cyc(3);
    sclk = 1'b1; cyc(3);
    sclk = 1'b0;
  endtask

  task automatic send_word(logic [19:0] w);
    for (int i = 19; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_enh(logic [7:0] w);
    e_wr = 1'b1; cyc(3);
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
    cyc(3); e_wr = 1'b0; cyc(3);
  endtask

  task automatic strobe(bit use_hop, bit use_swr);
    hop_wr = use_hop; s_wr = use_swr; cyc(4);
    hop_wr = 1'b0; s_wr = 1'b0; cyc(5);
  endtask

  function automatic logic [19:0] main_word(logic [8:0] m, logic [3:0] a, logic [5:0] r);
    return {m, a, r, 1'b0};
  endfunction

  initial begin
    // R8: outputs zero during reset and after release
    phase = "R8";
    cyc(5);
    rst_n = 1'b1;
    cyc(6);
    // R1 R3 R6: main word by S_WR, serial mode selected
    phase = "R1_R3";
    send_word(main_word(9'h1A5, 4'h9, 6'h2B));
    cyc(4);
    strobe(1'b0, 1'b1);
    send_word(main_word(9'h05A, 4'h6, 6'h15));
    strobe(1'b0, 1'b1);
    // R4: fractional word via hop strobe
    phase = "R4";
    send_word({18'h2C3A5, 1'b1, 1'b1});
    strobe(1'b1, 1'b0);
    send_word({18'h15A5A, 1'b0, 1'b1});
    strobe(1'b1, 1'b0);
    // R5: shifting alone changes nothing visible
    phase = "R5";
    send_word(main_word(9'h0FF, 4'hF, 6'h3F));
    cyc(10);
    // R2 R7: enhancement register, gate closed then open
    phase = "R2_R7";
    send_enh(8'hC5);
    cyc(4);
    enh_n = 1'b0; cyc(6);
    send_enh(8'h3A);
    cyc(6);
    enh_n = 1'b1; cyc(4);
    // R2: primary unchanged by enhancement shifting, then loaded
    phase = "R2";
    strobe(1'b0, 1'b1);
    // R6: direct pins, serial state kept
    phase = "R6";
    m_pin = 9'h123; a_pin = 4'hA; r_pin = 6'h31; k_pin = 18'h3FFFF;
    direct = 1'b1; cyc(3);
    m_pin = 9'h0F0; k_pin = 18'h00001; cyc(3);
    send_word(main_word(9'h111, 4'h2, 6'h07));
    strobe(1'b0, 1'b1);
    cyc(3);
    direct = 1'b0; cyc(6);
    direct = 1'b1; cyc(2);
    direct = 1'b0; cyc(6);
    // R9: strobe edge coincides with the last shift edge
    phase = "R9";
    send_word(main_word(9'h0AA, 4'h5, 6'h0C));
    for (int i = 19; i >= 1; i--) send_bit(main_word(9'h155, 4'hA, 6'h33)[i]);
    sdata = 1'b1; sclk = 1'b0; cyc(3);
    sclk = 1'b1; s_wr = 1'b1; cyc(4);
    sclk = 1'b0; s_wr = 1'b0; cyc(8);
    // R9: both strobes together produce one transfer
    strobe(1'b1, 1'b1);
    cyc(8);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule